// File: doc/BRIEF.md
# Codec Control Serial Write Engine

This block turns a host write request into a serial frame on the control port of one of several audio codecs. All codecs share one clock line and one data line. Each codec has its own active-low select. The frame is sixteen bits wide. It carries a fixed two-bit device identifier, a write flag, a five-bit register index and an eight-bit value, and it is sent most significant bit first. Every step of the line protocol lasts a programmable number of clock cycles, called a phase.

The engine keeps a shadow copy of every register it has written, one bank per codec. A second request mode uses these copies to apply a masked update to the same register index on every codec. For each codec in ascending index order, the engine takes the shadow value, clears the bits set in the mask, ORs in the supplied value, sends the result and stores it back. The host learns that a request has finished from a done pulse, and that a request was refused from a reject pulse.

Top module: `codec_ctl_writer`

## Requirements
- R1: A frame is `{2'b10, 1'b1, reg_index[4:0], value[7:0]}` and is shifted out MSB first, one bit per rising edge of `sclk_o`, so each frame has exactly 16 bits.
- R2: Out of reset, and whenever `busy_o` is low, `sclk_o`, `sdata_o` and every bit of `csn_o` are high.
- R3: An accepted request raises `busy_o` on the accepting edge. The lines stay high for one phase, and then only the select of the addressed codec goes low (codec k drives `csn_o[k]`).
- R4: Each bit takes three phases: clock low, then data set, then clock high. The clock is low for two phases and high for one. While a select is low, `sdata_o` changes only when `sclk_o` is low.
- R5: One phase after the 16th rising edge, the clock, the data line and the select all go high on the same edge. A further phase later, `busy_o` falls and `done_o` pulses for one cycle. A direct write keeps `busy_o` high for exactly 51 phases.
- R6: When `req_mode_i` = 0 and `req_codec_i` >= NUM_CODECS, the request is refused. `reject_o` pulses for one cycle, `busy_o` stays low, nothing moves on the bus, and no shadow value changes.
- R7: When `req_mode_i` = 1, one frame is sent to each codec, codec 0 first. Each frame's value is `(shadow & ~mask) | value`. `busy_o` stays high for 51 phases per codec, and a single `done_o` pulse follows the last frame.
- R8: Shadow values reset to zero. A codec's shadow entry takes the value sent to it when that codec's frame completes.
- R9: `req_valid_i` is ignored while `busy_o` is high.
- R10: In mask mode (`req_mode_i` = 1), `req_codec_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, sampled while idle |
| req_mode_i | input | 1 | 0 = direct write, 1 = masked update to all codecs |
| req_codec_i | input | IDX_W | Target codec for a direct write |
| req_addr_i | input | 5 | Codec register index |
| req_val_i | input | 8 | Value (direct) or OR-in value (masked) |
| req_mask_i | input | 8 | Bits to clear in the shadow value (masked mode only) |
| busy_o | output | 1 | High from accept until return to idle |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| reject_o | output | 1 | One-cycle pulse for a refused codec index |
| sclk_o | output | 1 | Shared serial clock, idles high |
| sdata_o | output | 1 | Shared serial data, idles high |
| csn_o | output | NUM_CODECS | Active-low selects, one per codec |

## Verification
The hardest state to reach from the ports is the content of the shadow banks, because the block never reads them back. The bench exposes them by sending masked updates with a zero mask and a zero value. Each frame of such an update carries the stored byte unchanged, which shows that the banks start at zero and that rejected or ignored requests leave them untouched. A bench model of both banks is then checked through a sweep of direct writes over every register index on both codecs, followed by masked updates with differing mask and value patterns.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    localparam int CC_REG_W   = 5;
    localparam int CC_VAL_W   = 8;
    localparam int CC_FRAME_W = 3 + CC_REG_W + CC_VAL_W;
    localparam int CC_BIT_W   = $clog2(CC_FRAME_W);

    localparam logic [1:0] CC_DEV_ID = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SEL,
        ST_CLK_LO,
        ST_DAT,
        ST_CLK_HI,
        ST_TAIL
    } cc_state_e;

    function automatic logic [CC_FRAME_W-1:0] cc_pack(
        input logic [CC_REG_W-1:0] reg_index,
        input logic [CC_VAL_W-1:0] value
    );
        return {CC_DEV_ID, 1'b1, reg_index, value};
    endfunction

endpackage

// File: rtl/cc_phase_timer.sv
module cc_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = RELOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/cc_shadow_bank.sv
module cc_shadow_bank #(
    parameter int NUM_CODECS = 2,
    parameter int IDX_W      = 2,
    parameter int REG_W      = 5,
    parameter int VAL_W      = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [IDX_W-1:0] codec_i,
    input  logic [REG_W-1:0] addr_i,
    input  logic [VAL_W-1:0] wdata_i,
    output logic [VAL_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << REG_W;

    logic [VAL_W-1:0] rd_k [NUM_CODECS];

    for (genvar k = 0; k < NUM_CODECS; k++) begin : g_bank
        logic [VAL_W-1:0] mem_q [DEPTH];
        logic             hit;

        assign hit     = (codec_i == IDX_W'(k));
        assign rd_k[k] = mem_q[addr_i];

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                for (int a = 0; a < DEPTH; a++) begin
                    mem_q[a] <= '0;
                end
            end else if (we_i && hit) begin
                mem_q[addr_i] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_CODECS; k++) begin
            if (codec_i == IDX_W'(k)) begin
                rdata_o = rd_k[k];
            end
        end
    end

endmodule

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer
    import codec_ctl_pkg::*;
#(
    parameter int NUM_CODECS = 2,
    parameter int IDX_W      = 2,
    parameter int PHASE_CYC  = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  req_valid_i,
    input  logic                  req_mode_i,
    input  logic [IDX_W-1:0]      req_codec_i,
    input  logic [CC_REG_W-1:0]   req_addr_i,
    input  logic [CC_VAL_W-1:0]   req_val_i,
    input  logic [CC_VAL_W-1:0]   req_mask_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  reject_o,
    output logic                  sclk_o,
    output logic                  sdata_o,
    output logic [NUM_CODECS-1:0] csn_o
);
    localparam logic [IDX_W-1:0]    LAST_CODEC = IDX_W'(NUM_CODECS - 1);
    localparam logic [CC_BIT_W-1:0] LAST_BIT   = CC_BIT_W'(CC_FRAME_W - 1);

    typedef struct packed {
        cc_state_e               st;
        logic [IDX_W-1:0]        cur;
        logic                    mode;
        logic [CC_REG_W-1:0]     addr;
        logic [CC_VAL_W-1:0]     val;
        logic [CC_VAL_W-1:0]     mask;
        logic [CC_VAL_W-1:0]     wval;
        logic [CC_FRAME_W-1:0]   shreg;
        logic [CC_BIT_W-1:0]     nbit;
        logic                    sclk;
        logic                    sdat;
        logic [NUM_CODECS-1:0]   csn;
        logic                    busy;
        logic                    done;
        logic                    rej;
    } seq_t;

    seq_t               seq_d, seq_q;
    logic               tmr_load, tmr_exp;
    logic               sh_we;
    logic [CC_VAL_W-1:0] sh_rdata;

    cc_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .expired_o (tmr_exp)
    );

    cc_shadow_bank #(
        .NUM_CODECS (NUM_CODECS),
        .IDX_W      (IDX_W),
        .REG_W      (CC_REG_W),
        .VAL_W      (CC_VAL_W)
    ) shadow_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (sh_we),
        .codec_i (seq_q.cur),
        .addr_i  (seq_q.addr),
        .wdata_i (seq_q.wval),
        .rdata_o (sh_rdata)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.rej  = 1'b0;
        tmr_load   = 1'b0;
        sh_we      = 1'b0;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (!req_mode_i && (int'(req_codec_i) >= NUM_CODECS)) begin
                        seq_d.rej = 1'b1;
                    end else begin
                        seq_d.mode = req_mode_i;
                        seq_d.cur  = req_mode_i ? '0 : req_codec_i;
                        seq_d.addr = req_addr_i;
                        seq_d.val  = req_val_i;
                        seq_d.mask = req_mask_i;
                        seq_d.busy = 1'b1;
                        seq_d.st   = ST_LEAD;
                        tmr_load   = 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                if (tmr_exp) begin
                    seq_d.wval  = seq_q.mode ? ((sh_rdata & ~seq_q.mask) | seq_q.val)
                                             : seq_q.val;
                    seq_d.shreg = cc_pack(seq_q.addr, seq_d.wval);
                    seq_d.nbit  = '0;
                    for (int k = 0; k < NUM_CODECS; k++) begin
                        seq_d.csn[k] = (seq_q.cur != IDX_W'(k));
                    end
                    seq_d.st = ST_SEL;
                    tmr_load = 1'b1;
                end
            end
            ST_SEL: begin
                if (tmr_exp) begin
                    seq_d.sclk = 1'b0;
                    seq_d.st   = ST_CLK_LO;
                    tmr_load   = 1'b1;
                end
            end
            ST_CLK_LO: begin
                if (tmr_exp) begin
                    seq_d.sdat = seq_q.shreg[CC_FRAME_W-1];
                    seq_d.st   = ST_DAT;
                    tmr_load   = 1'b1;
                end
            end
            ST_DAT: begin
                if (tmr_exp) begin
                    seq_d.sclk = 1'b1;
                    seq_d.st   = ST_CLK_HI;
                    tmr_load   = 1'b1;
                end
            end
            ST_CLK_HI: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (seq_q.nbit == LAST_BIT) begin
                        seq_d.sclk = 1'b1;
                        seq_d.sdat = 1'b1;
                        seq_d.csn  = '1;
                        sh_we      = 1'b1;
                        seq_d.st   = ST_TAIL;
                    end else begin
                        seq_d.shreg = {seq_q.shreg[CC_FRAME_W-2:0], 1'b0};
                        seq_d.nbit  = seq_q.nbit + 1'b1;
                        seq_d.sclk  = 1'b0;
                        seq_d.st    = ST_CLK_LO;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_exp) begin
                    if (seq_q.mode && (seq_q.cur != LAST_CODEC)) begin
                        seq_d.cur = seq_q.cur + 1'b1;
                        seq_d.st  = ST_LEAD;
                        tmr_load  = 1'b1;
                    end else begin
                        seq_d.busy = 1'b0;
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_IDLE;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.sclk <= 1'b1;
            seq_q.sdat <= 1'b1;
            seq_q.csn  <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o   = seq_q.busy;
    assign done_o   = seq_q.done;
    assign reject_o = seq_q.rej;
    assign sclk_o   = seq_q.sclk;
    assign sdata_o  = seq_q.sdat;
    assign csn_o    = seq_q.csn;

endmodule

// File: rtl/codec_ctl_writer_chk.sv
module codec_ctl_writer_chk #(
    parameter int NUM_CODECS = 2
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  reject_o,
    input logic                  sclk_o,
    input logic                  sdata_o,
    input logic [NUM_CODECS-1:0] csn_o
);
    // R2
    idle_lines_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (sclk_o && sdata_o && (&csn_o)));

    // R3
    single_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~csn_o) <= 1);

    // R4
    data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o && $past(sclk_o) && !(&csn_o) && !(&$past(csn_o)))
            |-> (sdata_o == $past(sdata_o)));

    // R4
    clock_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sclk_o) |-> !(&csn_o));

    // R5
    done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    // R6
    reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reject_o |-> (!busy_o && !$past(busy_o) && (&csn_o)));

endmodule

bind codec_ctl_writer codec_ctl_writer_chk #(.NUM_CODECS(NUM_CODECS)) chk_i (.*);

// File: tb/codec_ctl_writer_tb_top.sv
`timescale 1ns/1ps
module codec_ctl_writer_tb_top;
    localparam int P  = 3;
    localparam int NC = 2;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_mode = 1'b0;
    logic [IW-1:0] req_codec = '0;
    logic [4:0]    req_addr = '0;
    logic [7:0]    req_val = '0;
    logic [7:0]    req_mask = '0;
    logic          busy_o, done_o, reject_o, sclk_o, sdata_o;
    logic [NC-1:0] csn_o;

    codec_ctl_writer #(.NUM_CODECS(NC), .IDX_W(IW), .PHASE_CYC(P)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
        .req_codec_i(req_codec), .req_addr_i(req_addr), .req_val_i(req_val),
        .req_mask_i(req_mask), .busy_o(busy_o), .done_o(done_o), .reject_o(reject_o),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .csn_o(csn_o)
    );

    int checks = 0;
    int fails = 0;
    logic finished = 1'b0;

    // bus monitor
    logic pr_sclk = 1'b1, pr_sdat = 1'b1;
    logic [NC-1:0] pr_csn = '1;
    int lo_cnt, hi_cnt, tim_err, end_err, idle_err, nbits, nframes;
    int busy_cnt, done_cnt, rej_cnt, lead_gap;
    logic lead_seen;
    logic [15:0] acc;
    logic [15:0] fr_val [4];
    logic [NC-1:0] fr_cs [4];

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_cnt++;
            if (done_o) done_cnt++;
            if (reject_o) rej_cnt++;
            if ((&pr_csn) && !(&csn_o)) begin
                if (!lead_seen) begin lead_gap = busy_cnt - 1; lead_seen = 1'b1; end
                hi_cnt = 1; lo_cnt = 0; nbits = 0;
            end else if (!(&pr_csn) && (&csn_o)) begin
                if (hi_cnt != P || !sclk_o || !sdata_o || nbits != 16) end_err++;
                if (nframes < 4) begin fr_val[nframes] = acc; fr_cs[nframes] = pr_csn; end
                nframes++;
            end else if (!(&csn_o)) begin
                if (!pr_sclk && sclk_o) begin
                    if (lo_cnt != 2*P) tim_err++;
                    lo_cnt = 0; hi_cnt = 1;
                    acc = {acc[14:0], sdata_o};
                    nbits++;
                end else if (pr_sclk && !sclk_o) begin
                    if (hi_cnt != P) tim_err++;
                    hi_cnt = 0; lo_cnt = 1;
                end else if (sclk_o) begin
                    hi_cnt++;
                    if (sdata_o != pr_sdat) tim_err++;
                end else begin
                    lo_cnt++;
                end
            end else if (!sclk_o || !sdata_o) begin
                idle_err++;
            end
            pr_sclk = sclk_o; pr_sdat = sdata_o; pr_csn = csn_o;
        end
    end

    logic [7:0] model [NC][32];

    function automatic logic [15:0] exp_frame(input logic [4:0] a, input logic [7:0] d);
        return {2'b10, 1'b1, a, d};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        busy_cnt = 0; done_cnt = 0; rej_cnt = 0; tim_err = 0; end_err = 0;
        idle_err = 0; nframes = 0; lead_seen = 1'b0; lead_gap = -1;
    endtask

    task automatic send(input logic mode, input logic [IW-1:0] c, input logic [4:0] a,
                        input logic [7:0] v, input logic [7:0] m);
        @(negedge clk); #1;
        clr_mon();
        req_mode = mode; req_codec = c; req_addr = a; req_val = v; req_mask = m;
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        for (int t = 0; t < 400 && done_cnt == 0 && rej_cnt == 0; t++) begin
            @(negedge clk); #1;
        end
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic check_frame(input int idx, input int c, input logic [4:0] a,
                               input logic [7:0] d, input string req);
        logic [NC-1:0] cs_exp;
        cs_exp = '1;
        cs_exp[c] = 1'b0;
        chk(fr_val[idx] == exp_frame(a, d), req, "frame bits", fr_val[idx], exp_frame(a, d));
        chk(fr_cs[idx] == cs_exp, req, "select", fr_cs[idx], cs_exp);
    endtask

    task automatic masked(input logic [IW-1:0] c, input logic [4:0] a,
                          input logic [7:0] v, input logic [7:0] m, input string req);
        logic [7:0] e [NC];
        for (int k = 0; k < NC; k++) e[k] = (model[k][a] & ~m) | v;
        send(1'b1, c, a, v, m);
        chk(nframes == NC, req, "frame count", nframes, NC);
        for (int k = 0; k < NC; k++) begin
            check_frame(k, k, a, e[k], req);
            model[k][a] = e[k];
        end
        chk(busy_cnt == 51*P*NC, "R7", "busy cycles", busy_cnt, 51*P*NC);
        chk(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
        chk(tim_err == 0 && end_err == 0, "R4/R5 timing", "errors", tim_err + end_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NC; k++) for (int a = 0; a < 32; a++) model[k][a] = 8'h00;
        clr_mon();
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(sclk_o && sdata_o && (&csn_o), "R2", "lines in reset", {sclk_o, sdata_o, csn_o}, 4'hF);
        chk(!busy_o && !done_o && !reject_o, "R2", "flags in reset", {busy_o, done_o, reject_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sclk_o && sdata_o && (&csn_o) && !busy_o, "R2", "lines after reset",
            {busy_o, sclk_o, sdata_o, csn_o}, 4'hF);

        // R8: shadows start at zero (mask 0, value 0 reads them out); R7 order
        masked(2'd0, 5'd5, 8'h00, 8'h00, "R8");
        masked(2'd0, 5'd31, 8'h00, 8'h00, "R8");

        // R1 R3 R5: direct writes over every index on both codecs
        for (int c = 0; c < NC; c++) begin
            for (int a = 0; a < 32; a++) begin
                logic [7:0] d;
                d = 8'((a * 37 + c * 85 + 3) & 8'hFF);
                send(1'b0, IW'(c), 5'(a), d, 8'hA5);
                chk(nframes == 1, "R1", "frame count", nframes, 1);
                check_frame(0, c, 5'(a), d, "R1");
                model[c][a] = d;
                chk(lead_gap == P, "R3", "lead phase", lead_gap, P);
                chk(busy_cnt == 51*P, "R5", "busy cycles", busy_cnt, 51*P);
                chk(done_cnt == 1, "R5", "done pulses", done_cnt, 1);
                chk(tim_err == 0, "R4", "bit timing errors", tim_err, 0);
                chk(end_err == 0, "R5", "frame end errors", end_err, 0);
            end
        end

        // R6: out-of-range codec index
        for (int c = NC; c < (1 << IW); c++) begin
            send(1'b0, IW'(c), 5'd4, 8'hEE, 8'h00);
            chk(rej_cnt == 1, "R6", "reject pulses", rej_cnt, 1);
            chk(busy_cnt == 0 && nframes == 0 && idle_err == 0, "R6", "bus activity",
                busy_cnt + nframes + idle_err, 0);
            chk(done_cnt == 0, "R6", "done pulses", done_cnt, 0);
        end
        masked(2'd0, 5'd4, 8'h00, 8'h00, "R6");

        // R7 R10: masked updates with a codec field that must be ignored
        masked(2'd3, 5'd3,  8'h0A, 8'hF0, "R10");
        masked(2'd1, 5'd31, 8'hC0, 8'h0F, "R7");
        masked(2'd2, 5'd0,  8'h3C, 8'hFF, "R10");
        masked(2'd0, 5'd17, 8'h81, 8'h00, "R7");

        // R9: requests while busy are ignored
        @(negedge clk); #1;
        clr_mon();
        req_mode = 1'b0; req_codec = 2'd0; req_addr = 5'd9; req_val = 8'h5A; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        req_mode = 1'b1; req_codec = 2'd1; req_val = 8'hFF; req_mask = 8'hFF; req_valid = 1'b1;
        repeat (30) @(negedge clk);
        #1;
        req_valid = 1'b0;
        for (int t = 0; t < 400 && done_cnt == 0; t++) begin
            @(negedge clk); #1;
        end
        repeat (10) @(negedge clk);
        #1;
        chk(nframes == 1, "R9", "frame count", nframes, 1);
        check_frame(0, 0, 5'd9, 8'h5A, "R9");
        model[0][9] = 8'h5A;
        chk(done_cnt == 1 && !busy_o, "R9", "done pulses", done_cnt, 1);
        masked(2'd0, 5'd9, 8'h00, 8'h00, "R9");

        // R8: final readback of a few entries
        masked(2'd0, 5'd20, 8'h00, 8'h00, "R8");
        masked(2'd0, 5'd3,  8'h00, 8'h00, "R8");

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule